// File: doc/BRIEF.md
# Three-Phase Calibrated LMS Filter with Soft-Error Canceller

This block is an adaptive FIR filter that runs beside a short error-cancelling FIR. The two share one least-mean-square weight-update engine. A sequencer steps the pair through three operating phases:

- **Filter calibration.** The main filter learns from a desired signal, at nominal supply.
- **Canceller calibration.** An overscaled supply is requested. Soft errors now appear on the main filter output, and the canceller learns to estimate them.
- **Soft filtering.** Both weight banks are frozen. The canceller estimate is subtracted from every output sample.

A start pulse launches calibration from idle. A start pulse that arrives during soft filtering restarts the same phase order at the next valid sample. Each calibration phase lasts a programmable number of valid samples. An injection port adds a soft-error value to the main filter output. That port only takes effect while the overscaled supply is requested. Outputs are the corrected sample, the current phase, the four control strobes, a one-cycle phase-change pulse, a convergence flag and the supply-overscale request.

Top module: `cal_lms_canceller`

## Requirements
- R1: During and right after reset the block reports:
  - phase code 0 (idle);
  - control strobes 4'b0000;
  - phase-change pulse, convergence flag, overscale request and output valid all low.
- R2: A start pulse in idle moves the phase to code 1 (filter calibration) at the next clock edge, with no valid sample needed. In phase 1 the strobe vector is 4'b1001 and the overscale request is low. The strobe bits are: bit0 main update, bit1 canceller update, bit2 canceller subtraction, bit3 desired-signal enable.
- R3: Phase 1 moves to phase code 2 (canceller calibration) on the valid sample that completes the main-calibration count. In phase 2 the strobes are 4'b1110 and the overscale request is high.
- R4: Phase 2 moves to phase code 3 (soft filtering) on the valid sample that completes the canceller-calibration count. In phase 3 the strobes are 4'b0100, and both the convergence flag and the overscale request are high.
- R5: The phase-change output is high for exactly the one cycle that follows each phase transition, and low at all other times.
- R6: One cycle after each valid input sample, output valid is high and the output carries a value built in three steps:
  - the main FIR result;
  - plus the injected soft error while the overscale request is high;
  - minus the canceller estimate while subtraction is enabled.

  Each FIR output is its accumulated sum arithmetically shifted right by FRAC and kept to 16 bits.
- R7: The soft-error port has no effect on output or weights in idle or in phase 1.
- R8: Weight update rule and timing:
  - Main weights change only on valid samples in phase 1: w += (err*x) >>> MU_SH, with err = desired − main output.
  - Canceller weights change only on valid samples in phase 2, by the same rule, with err = final output − desired.
  - The two banks never adapt in the same cycle.
- R9: A start pulse in phase 3 is held until the next valid sample, which returns the phase to code 1. A start pulse in phase 1 or phase 2 is ignored.
- R10: A programmed length of 0 behaves like a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Calibration start or recalibration request pulse |
| sample_vld_i | input | 1 | Input sample valid |
| sample_i | input | 16 | Input sample, signed |
| desired_i | input | 16 | Desired signal for calibration, signed |
| soft_err_i | input | 16 | Injected soft-error value, signed |
| cal_len_main_i | input | CNTW | Valid samples spent in filter calibration |
| cal_len_canc_i | input | CNTW | Valid samples spent in canceller calibration |
| out_sample_o | output | 16 | Corrected filter output, signed |
| out_vld_o | output | 1 | Output valid |
| phase_o | output | 2 | Current phase code (0 idle, 1, 2, 3) |
| ctrl_o | output | 4 | Control strobes {desired en, subtract, canceller upd, main upd} |
| phase_chg_o | output | 1 | One-cycle pulse after each phase transition |
| converged_o | output | 1 | Calibration complete (phase 3) |
| vos_req_o | output | 1 | Overscaled supply request |

## Verification
The same valid sample can be the last sample of a phase and also update a weight bank under that phase's strobes. The sample that ends phase 1 must still adapt only the main weights, and its output must not include the injected error. The sample after it must already use the phase 2 strobes.

The bench provokes this at every phase boundary with a nonzero soft error and back-to-back samples. A scoreboard predicts each output from its own weight model, so a strobe applied one sample early or late shows up as an output mismatch. It also pairs a recalibration pulse with a later valid sample, and uses zero and unit lengths so that transitions fall on consecutive samples.

// File: rtl/calf_pkg.sv
package calf_pkg;

    localparam int DW = 16;
    localparam int CW = 16;

    typedef logic signed [DW-1:0] samp_t;
    typedef logic signed [CW-1:0] coef_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FCAL = 2'd1,
        PH_CCAL = 2'd2,
        PH_SOFT = 2'd3
    } phase_e;

    typedef struct packed {
        logic des_en;
        logic sub_en;
        logic upd_canc;
        logic upd_main;
    } ctrl_t;

    function automatic ctrl_t phase_ctrl(phase_e ph);
        ctrl_t c;
        c = '0;
        case (ph)
            PH_FCAL: begin
                c.upd_main = 1'b1;
                c.des_en   = 1'b1;
            end
            PH_CCAL: begin
                c.upd_canc = 1'b1;
                c.sub_en   = 1'b1;
                c.des_en   = 1'b1;
            end
            PH_SOFT: c.sub_en = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic logic phase_overscaled(phase_e ph);
        return (ph == PH_CCAL) || (ph == PH_SOFT);
    endfunction

endpackage

// File: rtl/calf_seq.sv
module calf_seq
    import calf_pkg::*;
#(
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            vld,
    input  logic [CNTW-1:0] len_main,
    input  logic [CNTW-1:0] len_canc,
    output phase_e          phase,
    output logic            chg,
    output logic            converged
);
    logic [CNTW-1:0] cnt;
    logic            pend;
    logic            last_main;
    logic            last_canc;

    // a length of zero finishes on the first sample, as a length of one would
    assign last_main = ({1'b0, cnt} + 1'b1) >= {1'b0, len_main};
    assign last_canc = ({1'b0, cnt} + 1'b1) >= {1'b0, len_canc};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            pend  <= 1'b0;
            chg   <= 1'b0;
        end else begin
            chg <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_FCAL;
                        cnt   <= '0;
                        chg   <= 1'b1;
                    end
                end
                PH_FCAL: begin
                    if (vld) begin
                        if (last_main) begin
                            phase <= PH_CCAL;
                            cnt   <= '0;
                            chg   <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_CCAL: begin
                    if (vld) begin
                        if (last_canc) begin
                            phase <= PH_SOFT;
                            cnt   <= '0;
                            chg   <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (vld && (start || pend)) begin
                        phase <= PH_FCAL;
                        cnt   <= '0;
                        pend  <= 1'b0;
                        chg   <= 1'b1;
                    end else if (start) begin
                        pend <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign converged = (phase == PH_SOFT);

endmodule

// File: rtl/calf_fir.sv
module calf_fir
    import calf_pkg::*;
#(
    parameter int TAPS = 4,
    parameter int FRAC = 8
) (
    input  samp_t [TAPS-1:0] win,
    input  coef_t [TAPS-1:0] coef,
    output samp_t            y
);
    localparam int ACCW = DW + CW + $clog2(TAPS + 1);

    logic signed [ACCW-1:0] prod [TAPS];
    logic signed [ACCW-1:0] acc;
    logic signed [ACCW-1:0] scaled;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign prod[k] = ACCW'($signed(win[k])) * ACCW'($signed(coef[k]));
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            acc = acc + prod[k];
        end
        scaled = acc >>> FRAC;
    end

    assign y = scaled[DW-1:0];

endmodule

// File: rtl/calf_wud.sv
module calf_wud
    import calf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int MU_SH = 10
) (
    input  samp_t [LANES-1:0] win,
    input  samp_t             err,
    input  coef_t [LANES-1:0] coef_in,
    output coef_t [LANES-1:0] coef_out
);
    localparam int PW = 2 * DW;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [PW-1:0] prod;
        logic signed [PW-1:0] step;
        assign prod        = PW'($signed(err)) * PW'($signed(win[k]));
        assign step        = prod >>> MU_SH;
        assign coef_out[k] = coef_in[k] + step[CW-1:0];
    end

endmodule

// File: rtl/cal_lms_canceller.sv
module cal_lms_canceller
    import calf_pkg::*;
#(
    parameter int MAIN_TAPS = 4,
    parameter int CANC_TAPS = 2,
    parameter int FRAC      = 8,
    parameter int MU_SH     = 10,
    parameter int CNTW      = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 sample_vld_i,
    input  logic signed [15:0]   sample_i,
    input  logic signed [15:0]   desired_i,
    input  logic signed [15:0]   soft_err_i,
    input  logic [CNTW-1:0]      cal_len_main_i,
    input  logic [CNTW-1:0]      cal_len_canc_i,
    output logic signed [15:0]   out_sample_o,
    output logic                 out_vld_o,
    output logic [1:0]           phase_o,
    output logic [3:0]           ctrl_o,
    output logic                 phase_chg_o,
    output logic                 converged_o,
    output logic                 vos_req_o
);
    localparam int LINE_N = MAIN_TAPS - 1;

    phase_e ph;
    ctrl_t  ctl;
    logic   overscaled;

    samp_t [LINE_N-1:0]    line_q;
    samp_t [MAIN_TAPS-1:0] win;
    coef_t [MAIN_TAPS-1:0] wmain_q;
    coef_t [CANC_TAPS-1:0] wcanc_q;
    coef_t [MAIN_TAPS-1:0] wud_in;
    coef_t [MAIN_TAPS-1:0] wud_out;
    coef_t [MAIN_TAPS-1:0] wcanc_wide;

    samp_t y_main, y_canc, se_eff, y_vos, y_fin, d_eff, err;

    calf_seq #(.CNTW(CNTW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .vld       (sample_vld_i),
        .len_main  (cal_len_main_i),
        .len_canc  (cal_len_canc_i),
        .phase     (ph),
        .chg       (phase_chg_o),
        .converged (converged_o)
    );

    assign ctl        = phase_ctrl(ph);
    assign overscaled = phase_overscaled(ph);

    // sample window: newest sample first, then the delay line
    assign win[0] = sample_i;
    for (genvar k = 1; k < MAIN_TAPS; k++) begin : g_win
        assign win[k] = line_q[k-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else if (sample_vld_i) begin
            line_q[0] <= sample_i;
            for (int k = 1; k < LINE_N; k++) begin
                line_q[k] <= line_q[k-1];
            end
        end
    end

    calf_fir #(.TAPS(MAIN_TAPS), .FRAC(FRAC)) u_main (
        .win  (win),
        .coef (wmain_q),
        .y    (y_main)
    );

    calf_fir #(.TAPS(CANC_TAPS), .FRAC(FRAC)) u_canc (
        .win  (win[CANC_TAPS-1:0]),
        .coef (wcanc_q),
        .y    (y_canc)
    );

    // output path
    always_comb begin
        se_eff = overscaled ? soft_err_i : '0;
        y_vos  = y_main + se_eff;
        y_fin  = ctl.sub_en ? samp_t'(y_vos - y_canc) : y_vos;
        d_eff  = ctl.des_en ? desired_i : '0;
        err    = ctl.upd_main ? samp_t'(d_eff - y_main) : samp_t'(y_fin - d_eff);
    end

    // shared weight-update engine, fed by whichever bank the phase selects
    for (genvar k = 0; k < MAIN_TAPS; k++) begin : g_pad
        if (k < CANC_TAPS) begin : g_use
            assign wcanc_wide[k] = wcanc_q[k];
        end else begin : g_zero
            assign wcanc_wide[k] = '0;
        end
    end

    assign wud_in = ctl.upd_main ? wmain_q : wcanc_wide;

    calf_wud #(.LANES(MAIN_TAPS), .MU_SH(MU_SH)) u_wud (
        .win      (win),
        .err      (err),
        .coef_in  (wud_in),
        .coef_out (wud_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wmain_q <= '0;
            wcanc_q <= '0;
        end else if (sample_vld_i) begin
            if (ctl.upd_main) begin
                wmain_q <= wud_out;
            end else if (ctl.upd_canc) begin
                wcanc_q <= wud_out[CANC_TAPS-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sample_o <= '0;
            out_vld_o    <= 1'b0;
        end else begin
            out_vld_o <= sample_vld_i;
            if (sample_vld_i) begin
                out_sample_o <= y_fin;
            end
        end
    end

    assign phase_o   = ph;
    assign ctrl_o    = ctl;
    assign vos_req_o = overscaled;

endmodule

// File: rtl/calf_checker.sv
module calf_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       sample_vld_i,
    input logic [1:0] phase_o,
    input logic [3:0] ctrl_o,
    input logic       phase_chg_o,
    input logic       converged_o,
    input logic       vos_req_o,
    input logic       out_vld_o
);
    AST_ONE_BANK_ADAPTS: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_o[0] && ctrl_o[1])); // R8

    AST_NO_MAIN_UPD_OVERSCALED: assert property (@(posedge clk) disable iff (rst)
        vos_req_o |-> !ctrl_o[0]); // R3

    AST_CONV_IMPLIES_VOS: assert property (@(posedge clk) disable iff (rst)
        converged_o |-> vos_req_o && !ctrl_o[1]); // R4

    AST_CHG_MARKS_MOVE: assert property (@(posedge clk) disable iff (rst)
        phase_chg_o |-> phase_o != $past(phase_o)); // R5

    AST_MOVE_MARKED: assert property (@(posedge clk) disable iff (rst)
        phase_o != $past(phase_o) |-> phase_chg_o); // R5

    AST_ENTER_CCAL: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd2 && $past(phase_o) != 2'd2) |-> $past(phase_o) == 2'd1 && $past(sample_vld_i)); // R3

    AST_ENTER_SOFT: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd3 && $past(phase_o) != 2'd3) |-> $past(phase_o) == 2'd2 && $past(sample_vld_i)); // R4

    AST_ENTER_FCAL: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd1 && $past(phase_o) != 2'd1) |->
            ($past(phase_o) == 2'd0 && $past(start_i)) || ($past(phase_o) == 2'd3 && $past(sample_vld_i))); // R9

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_vld_o == $past(sample_vld_i)); // R6

endmodule

bind cal_lms_canceller calf_checker u_calf_checker (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .sample_vld_i (sample_vld_i),
    .phase_o      (phase_o),
    .ctrl_o       (ctrl_o),
    .phase_chg_o  (phase_chg_o),
    .converged_o  (converged_o),
    .vos_req_o    (vos_req_o),
    .out_vld_o    (out_vld_o)
);

// File: tb/tb_cal_lms_canceller.sv
module tb_cal_lms_canceller;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start_i = 1'b0;
    logic               sample_vld_i = 1'b0;
    logic signed [15:0] sample_i = '0;
    logic signed [15:0] desired_i = '0;
    logic signed [15:0] soft_err_i = '0;
    logic [15:0]        cal_len_main_i = 16'd6;
    logic [15:0]        cal_len_canc_i = 16'd4;
    logic signed [15:0] out_sample_o;
    logic               out_vld_o;
    logic [1:0]         phase_o;
    logic [3:0]         ctrl_o;
    logic               phase_chg_o;
    logic               converged_o;
    logic               vos_req_o;

    always #10 clk = ~clk;

    cal_lms_canceller dut (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .sample_vld_i   (sample_vld_i),
        .sample_i       (sample_i),
        .desired_i      (desired_i),
        .soft_err_i     (soft_err_i),
        .cal_len_main_i (cal_len_main_i),
        .cal_len_canc_i (cal_len_canc_i),
        .out_sample_o   (out_sample_o),
        .out_vld_o      (out_vld_o),
        .phase_o        (phase_o),
        .ctrl_o         (ctrl_o),
        .phase_chg_o    (phase_chg_o),
        .converged_o    (converged_o),
        .vos_req_o      (vos_req_o)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    typedef struct {
        longint val;
        string  tag;
    } exp_t;
    exp_t exp_q[$];

    // reference model state
    int     mph  = 0;
    int     mcnt = 0;
    bit     mpend = 0;
    longint W[4];
    longint G[2];
    longint L[3];

    function automatic longint s16(longint v);
        logic signed [15:0] t;
        t = v[15:0];
        return t;
    endfunction

    task automatic check(string tag, longint act, longint expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int ctrl_of(int ph);
        case (ph)
            1: return 4'b1001;
            2: return 4'b1110;
            3: return 4'b0100;
            default: return 0;
        endcase
    endfunction

    task automatic seq_step(input bit vld, input bit st, output bit chg);
        longint lm, lc;
        lm = (cal_len_main_i == 0) ? 1 : cal_len_main_i;
        lc = (cal_len_canc_i == 0) ? 1 : cal_len_canc_i;
        chg = 0;
        case (mph)
            0: if (st) begin mph = 1; mcnt = 0; chg = 1; end
            1: if (vld) begin
                   if (mcnt + 1 >= lm) begin mph = 2; mcnt = 0; chg = 1; end
                   else mcnt++;
               end
            2: if (vld) begin
                   if (mcnt + 1 >= lc) begin mph = 3; mcnt = 0; chg = 1; end
                   else mcnt++;
               end
            default: if (vld && (st || mpend)) begin
                         mph = 1; mcnt = 0; mpend = 0; chg = 1;
                     end else if (st) mpend = 1;
        endcase
    endtask

    task automatic check_status(string tag, bit chg);
        check({tag, " phase"}, phase_o, mph);
        check({tag, " ctrl"}, ctrl_o, ctrl_of(mph));
        check({tag, " vos_req"}, vos_req_o, (mph >= 2));
        check({tag, " converged"}, converged_o, (mph == 3));
        check({tag, " R5 phase_chg"}, phase_chg_o, chg);
    endtask

    // driver: called at a falling edge, returns at the next falling edge
    task automatic send(longint x, longint d, longint se, bit st, string tag);
        longint win[4];
        longint acc, ym, yv, yc, yf, de, err;
        bit upm, upc, sub, des, vos, chg;
        exp_t e;
        sample_i = 16'(x); desired_i = 16'(d); soft_err_i = 16'(se);
        sample_vld_i = 1'b1; start_i = st;
        win[0] = x; win[1] = L[0]; win[2] = L[1]; win[3] = L[2];
        upm = (mph == 1); upc = (mph == 2); sub = (mph >= 2);
        des = (mph == 1 || mph == 2); vos = (mph >= 2);
        acc = 0;
        for (int k = 0; k < 4; k++) acc += W[k] * win[k];
        ym = s16(acc >>> 8);
        yv = s16(ym + (vos ? se : 0));
        yc = s16((G[0] * win[0] + G[1] * win[1]) >>> 8);
        yf = sub ? s16(yv - yc) : yv;
        e.val = yf; e.tag = tag;
        exp_q.push_back(e);
        de  = des ? d : 0;
        err = upm ? s16(de - ym) : s16(yf - de);
        if (upm) for (int k = 0; k < 4; k++) W[k] = s16(W[k] + s16((err * win[k]) >>> 10));
        if (upc) for (int k = 0; k < 2; k++) G[k] = s16(G[k] + s16((err * win[k]) >>> 10));
        L[2] = L[1]; L[1] = L[0]; L[0] = x;
        seq_step(1'b1, st, chg);
        @(posedge clk);
        @(negedge clk);
        sample_vld_i = 1'b0; start_i = 1'b0;
        check_status(tag, chg);
    endtask

    task automatic pulse_start(string tag);
        bit chg;
        start_i = 1'b1;
        seq_step(1'b0, 1'b1, chg);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check_status(tag, chg);
    endtask

    function automatic longint xs(int i);
        return ((i * 37) % 101) - 50;
    endfunction

    // monitor: compares every produced sample with the scoreboard
    always @(negedge clk) begin
        if (!rst && out_vld_o) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected output", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, out_sample_o, e.val);
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) W[k] = 0;
        for (int k = 0; k < 2; k++) G[k] = 0;
        for (int k = 0; k < 3; k++) L[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset phase", phase_o, 0);
        check("R1 reset ctrl", ctrl_o, 0);
        check("R1 reset flags", {phase_chg_o, converged_o, vos_req_o, out_vld_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset phase", phase_o, 0);
        check("R1 after reset out_vld", out_vld_o, 0);

        // idle samples with soft errors injected: R7
        for (int i = 0; i < 3; i++) send(xs(i), 5, 300, 0, "R7 idle soft err ignored");

        pulse_start("R2 start from idle");

        // filter calibration with soft errors on the port: R7, R8, R3 at the end
        for (int i = 0; i < 6; i++)
            send(xs(i + 3), (xs(i + 3) * 3) / 2, 200, 0, "R7 R8 phase1 output");
        check("R3 reached canceller calibration", phase_o, 2);

        // canceller calibration: R8, R6
        for (int i = 0; i < 4; i++)
            send(xs(i + 9), (xs(i + 9) * 3) / 2, 40 - 20 * i, 0, "R6 R8 phase2 output");
        check("R4 reached soft filtering", phase_o, 3);

        // soft filtering with frozen weights
        for (int i = 0; i < 4; i++)
            send(xs(i + 13), 0, 25, 0, "R6 R8 phase3 output");

        // recalibration held until next valid sample: R9
        pulse_start("R9 start held in phase3");
        check("R9 stays in phase3 without sample", phase_o, 3);
        idle_gap();
        send(xs(20), 10, 30, 0, "R9 recal sample");
        check("R9 back to phase1", phase_o, 1);

        // start in phase 1 is ignored: R9
        pulse_start("R9 start ignored in phase1");
        check("R9 phase1 unchanged", phase_o, 1);

        // finish with zero and unit lengths: R10
        cal_len_main_i = 16'd0;
        cal_len_canc_i = 16'd1;
        send(xs(21), 12, 50, 0, "R10 len0 phase1");
        check("R10 zero length ends phase1", phase_o, 2);
        send(xs(22), 12, 50, 0, "R10 len1 phase2");
        check("R10 unit length ends phase2", phase_o, 3);
        send(xs(23), 0, -60, 1, "R9 start with sample in phase3");
        check("R9 immediate recal", phase_o, 1);

        repeat (3) @(negedge clk);
        check("R6 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic idle_gap();
        @(negedge clk);
    endtask

endmodule